// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

A synchronous two-port memory of 4096 bits in which each port runs on its own clock and has its own enable, write enable, synchronous output clear, address and data buses. A parameter sets the data width of each port to 1, 2, 4, 8 or 16 bits, and both ports see the same bit array. A port of width W at address A covers bits A*W through (A+1)*W-1, so a 16-bit port and a 4-bit port can exchange data through the same storage. Every access is a single clock edge with a registered output. A write also drives the written word onto that port's read data.

When both ports act on the same edge and their bit ranges overlap with at least one of them writing, the block treats this as a collision. If both ports write, the overlapping stored bits are marked poisoned. Any later read that touches a poisoned bit raises that port's invalid flag, until a clean write replaces those bits. If one port writes while the other reads, the write is stored and the writer's output is correct, but the reader's invalid flag is raised. A sticky collision flag records that such an event occurred. It lives in port A's clock domain and is cleared by port A's output clear. Each control pin and each clock has its own polarity inversion parameter. The initial contents come from sixteen 256-bit vectors.

Elaboration fails on an unsupported width. Collision detection is only meaningful when both ports use the same effective clock.

Top module: `mwtdp_ram`

## Requirements
- R1: Both ports address one 4096-bit array. Port address A of width W selects bits A*W to A*W+W-1, with bit j of the word at array bit A*W+j. Data written by one port is read back by the other through this mapping.
- R2: With enable high and write enable low, the word at the address appears on the read data after that same clock edge, with the invalid flag low unless a collision or poisoned bit applies.
- R3: With enable and write enable high, the write data is stored and also appears on the same port's read data after the edge, with the invalid flag low.
- R4: With enable low, nothing is stored and the read data and invalid flag keep their previous values, even when write enable is high.
- R5: The port's output clear, sampled on the port clock, sets read data and the invalid flag to zero. It has priority over the read result and does not stop a write on the same port or any access on the other port. Memory contents are unchanged by it.
- R6: Parameters invert the polarity of each port's clock, enable, write enable and output clear individually. An inverted port behaves identically when its pins are driven inverted.
- R7: Initial contents come from 16 vectors of 256 bits: vector v fills array bits v*256 to v*256+255. Vectors left unset are zero.
- R8: When both ports write overlapping bits on the same edge, those bits become poisoned. A later read covering any poisoned bit raises the invalid flag, and a write without collision clears the poison of the bits it writes.
- R9: When one port writes and the other reads overlapping bits on the same edge, the write is stored and the writer's output shows the written data. The reader's invalid flag goes high.
- R10: The collision flag goes high after an edge where both ports are enabled, at least one writes, and their ranges overlap. It stays high until port A's output clear is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock (polarity per parameter) |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_srst | input | 1 | Port A synchronous output clear |
| a_addr | input | $clog2(4096/WA) | Port A word address |
| a_wdata | input | WA | Port A write data |
| a_rdata | output | WA | Port A read data |
| a_bad | output | 1 | Port A read data invalid |
| b_clk | input | 1 | Port B clock (polarity per parameter) |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_srst | input | 1 | Port B synchronous output clear |
| b_addr | input | $clog2(4096/WB) | Port B word address |
| b_wdata | input | WB | Port B write data |
| b_rdata | output | WB | Port B read data |
| b_bad | output | 1 | Port B read data invalid |
| coll_flag | output | 1 | Sticky collision indicator, port A domain |

## Verification
The bench runs a 16-bit port against a 4-bit port whose pins and clock are all inverted. It aims at nibble placement inside wide words: a design that swapped the mapping would return the wrong nibble from the narrow side. It creates partial overlaps in which the narrow port writes inside a wide word that is written or read on the same edge. A design that lost the poison would report clean data, and one that poisoned the whole wide word would flag the narrow neighbours. It also clears an output while a write is in flight, so a design where the clear blocked the write would show stale data on the later read.

// File: rtl/mwtdp_pkg.sv
package mwtdp_pkg;

   function automatic bit width_ok(input int w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
   endfunction

   // true when [sa, sa+la) and [sb, sb+lb) share at least one bit
   function automatic bit ranges_meet(input int sa, input int la,
                                      input int sb, input int lb);
      return (sa < sb + lb) && (sb < sa + la);
   endfunction

endpackage

// File: rtl/mwtdp_pol.sv
module mwtdp_pol #(
   parameter int  N   = 4,
   parameter logic [N-1:0] INV = '0
) (
   input  logic [N-1:0] raw,
   output logic [N-1:0] eff
);
   assign eff = raw ^ INV;
endmodule

// File: rtl/mwtdp_port.sv
module mwtdp_port #(
   parameter int   NBITS     = 4096,
   parameter int   W         = 16,
   parameter int   OW        = 4,
   parameter int   AW        = 8,
   parameter int   OAW       = 10,
   parameter bit   SECONDARY = 1'b0,
   parameter logic [NBITS-1:0] LAYER_INIT = '0
) (
   input  logic             clk,
   input  logic             en,
   input  logic             we,
   input  logic             srst,
   input  logic [AW-1:0]    addr,
   input  logic [W-1:0]     wdata,
   input  logic             o_en,
   input  logic             o_we,
   input  logic [OAW-1:0]   o_addr,
   input  logic [NBITS-1:0] o_lay,
   input  logic [NBITS-1:0] o_psn,
   output logic [NBITS-1:0] lay,
   output logic [NBITS-1:0] psn,
   output logic [W-1:0]     rdata,
   output logic             bad
);
   localparam int IW  = $clog2(NBITS);
   localparam int LW  = $clog2(W);
   localparam int OLW = $clog2(OW);

   // this port's share of the XOR-layered storage and poison map
   logic [NBITS-1:0] lay_q = LAYER_INIT;
   logic [NBITS-1:0] psn_q = '0;
   logic [W-1:0]     rd_q  = '0;
   logic             bad_q = 1'b0;

   logic [IW-1:0] base, obase;
   logic [W-1:0]  ovl, word, wpsn;
   logic          o_wr;

   always_comb begin
      base  = IW'(addr) << LW;
      obase = IW'(o_addr) << OLW;
      o_wr  = o_en && o_we;
      for (int j = 0; j < W; j++) begin
         ovl[j]  = ({1'b0, base + IW'(j)} >= {1'b0, obase}) &&
                   ({1'b0, base + IW'(j)} <  {1'b0, obase} + (IW+1)'(OW));
         word[j] = lay_q[base + IW'(j)] ^ o_lay[base + IW'(j)];
         wpsn[j] = psn_q[base + IW'(j)] ^ o_psn[base + IW'(j)];
      end
   end

   // storage layer: value = own ^ other, so each layer has one writer clock
   always_ff @(posedge clk) begin
      if (en && we) begin
         for (int j = 0; j < W; j++) begin
            if (!(SECONDARY && o_wr && ovl[j])) begin
               lay_q[base + IW'(j)] <= wdata[j] ^ o_lay[base + IW'(j)];
               psn_q[base + IW'(j)] <= (o_wr && ovl[j]) ^ o_psn[base + IW'(j)];
            end
         end
      end
   end

   // output register
   always_ff @(posedge clk) begin
      if (srst) begin
         rd_q  <= '0;
         bad_q <= 1'b0;
      end else if (en) begin
         if (we) begin
            rd_q  <= wdata;
            bad_q <= 1'b0;
         end else begin
            rd_q  <= word;
            bad_q <= (|wpsn) || (o_wr && (|ovl));
         end
      end
   end

   assign lay   = lay_q;
   assign psn   = psn_q;
   assign rdata = rd_q;
   assign bad   = bad_q;
endmodule

// File: rtl/mwtdp_ram.sv
module mwtdp_ram #(
   parameter int   MEM_BITS  = 4096,
   parameter int   NVEC      = 16,
   parameter int   WA        = 16,
   parameter int   WB        = 4,
   parameter bit   INV_CLK_A = 1'b0,
   parameter bit   INV_EN_A  = 1'b0,
   parameter bit   INV_WE_A  = 1'b0,
   parameter bit   INV_RST_A = 1'b0,
   parameter bit   INV_CLK_B = 1'b0,
   parameter bit   INV_EN_B  = 1'b0,
   parameter bit   INV_WE_B  = 1'b0,
   parameter bit   INV_RST_B = 1'b0,
   parameter logic [NVEC-1:0][MEM_BITS/NVEC-1:0] INIT_VEC = '0,
   localparam int  AWA = $clog2(MEM_BITS / WA),
   localparam int  AWB = $clog2(MEM_BITS / WB)
) (
   input  logic           a_clk,
   input  logic           a_en,
   input  logic           a_we,
   input  logic           a_srst,
   input  logic [AWA-1:0] a_addr,
   input  logic [WA-1:0]  a_wdata,
   output logic [WA-1:0]  a_rdata,
   output logic           a_bad,
   input  logic           b_clk,
   input  logic           b_en,
   input  logic           b_we,
   input  logic           b_srst,
   input  logic [AWB-1:0] b_addr,
   input  logic [WB-1:0]  b_wdata,
   output logic [WB-1:0]  b_rdata,
   output logic           b_bad,
   output logic           coll_flag
);
   import mwtdp_pkg::*;

   // elaboration-time parameter checks
   if (!width_ok(WA)) begin : g_bad_wa
      $error("mwtdp_ram: WA must be 1, 2, 4, 8 or 16");
   end
   if (!width_ok(WB)) begin : g_bad_wb
      $error("mwtdp_ram: WB must be 1, 2, 4, 8 or 16");
   end
   if (MEM_BITS % NVEC != 0) begin : g_bad_vec
      $error("mwtdp_ram: MEM_BITS must split evenly into NVEC vectors");
   end

   // polarity conditioning: {clk, en, we, srst}
   logic [3:0] a_eff, b_eff;
   mwtdp_pol #(.N(4), .INV({INV_CLK_A, INV_EN_A, INV_WE_A, INV_RST_A})) u_pol_a (
      .raw({a_clk, a_en, a_we, a_srst}), .eff(a_eff));
   mwtdp_pol #(.N(4), .INV({INV_CLK_B, INV_EN_B, INV_WE_B, INV_RST_B})) u_pol_b (
      .raw({b_clk, b_en, b_we, b_srst}), .eff(b_eff));

   logic a_clk_e, a_en_e, a_we_e, a_rst_e;
   logic b_clk_e, b_en_e, b_we_e, b_rst_e;
   assign {a_clk_e, a_en_e, a_we_e, a_rst_e} = a_eff;
   assign {b_clk_e, b_en_e, b_we_e, b_rst_e} = b_eff;

   logic [MEM_BITS-1:0] lay_a, lay_b, psn_a, psn_b;

   // port A holds the initial image; port B's layer starts at zero
   mwtdp_port #(.NBITS(MEM_BITS), .W(WA), .OW(WB), .AW(AWA), .OAW(AWB),
                .SECONDARY(1'b0), .LAYER_INIT(INIT_VEC)) u_port_a (
      .clk(a_clk_e), .en(a_en_e), .we(a_we_e), .srst(a_rst_e),
      .addr(a_addr), .wdata(a_wdata),
      .o_en(b_en_e), .o_we(b_we_e), .o_addr(b_addr),
      .o_lay(lay_b), .o_psn(psn_b),
      .lay(lay_a), .psn(psn_a), .rdata(a_rdata), .bad(a_bad));

   mwtdp_port #(.NBITS(MEM_BITS), .W(WB), .OW(WA), .AW(AWB), .OAW(AWA),
                .SECONDARY(1'b1), .LAYER_INIT('0)) u_port_b (
      .clk(b_clk_e), .en(b_en_e), .we(b_we_e), .srst(b_rst_e),
      .addr(b_addr), .wdata(b_wdata),
      .o_en(a_en_e), .o_we(a_we_e), .o_addr(a_addr),
      .o_lay(lay_a), .o_psn(psn_a),
      .lay(lay_b), .psn(psn_b), .rdata(b_rdata), .bad(b_bad));

   // sticky collision flag, port A domain
   logic hit;
   logic coll_q = 1'b0;
   assign hit = a_en_e && b_en_e && (a_we_e || b_we_e) &&
                ranges_meet(int'(a_addr) * WA, WA, int'(b_addr) * WB, WB);

   always_ff @(posedge a_clk_e) begin
      if (a_rst_e)  coll_q <= 1'b0;
      else if (hit) coll_q <= 1'b1;
   end

   assign coll_flag = coll_q;
endmodule

// File: rtl/mwtdp_ram_chk.sv
module mwtdp_ram_chk #(
   parameter int WA  = 16,
   parameter int WB  = 4,
   parameter int AWA = 8,
   parameter int AWB = 10
) (
   input logic           clk_a,
   input logic           clk_b,
   input logic           en_a,
   input logic           we_a,
   input logic           rst_a,
   input logic [AWA-1:0] addr_a,
   input logic [WA-1:0]  wdata_a,
   input logic [WA-1:0]  rdata_a,
   input logic           bad_a,
   input logic           en_b,
   input logic           we_b,
   input logic           rst_b,
   input logic [AWB-1:0] addr_b,
   input logic [WB-1:0]  wdata_b,
   input logic [WB-1:0]  rdata_b,
   input logic           bad_b,
   input logic           coll
);
   import mwtdp_pkg::*;

   logic live_a = 1'b0;
   logic live_b = 1'b0;
   always_ff @(posedge clk_a) live_a <= 1'b1;
   always_ff @(posedge clk_b) live_b <= 1'b1;

   logic meet;
   assign meet = ranges_meet(int'(addr_a) * WA, WA, int'(addr_b) * WB, WB);

   a_r5_clear_a: assert property (@(posedge clk_a) disable iff (!live_a)
      rst_a |=> (rdata_a == '0) && !bad_a);
   a_r5_clear_b: assert property (@(posedge clk_b) disable iff (!live_b)
      rst_b |=> (rdata_b == '0) && !bad_b);
   a_r4_idle_a: assert property (@(posedge clk_a) disable iff (!live_a)
      (!en_a && !rst_a) |=> $stable(rdata_a) && $stable(bad_a));
   a_r4_idle_b: assert property (@(posedge clk_b) disable iff (!live_b)
      (!en_b && !rst_b) |=> $stable(rdata_b) && $stable(bad_b));
   a_r3_mirror_a: assert property (@(posedge clk_a) disable iff (!live_a)
      (en_a && we_a && !rst_a) |=> (rdata_a == $past(wdata_a)) && !bad_a);
   a_r3_mirror_b: assert property (@(posedge clk_b) disable iff (!live_b)
      (en_b && we_b && !rst_b) |=> (rdata_b == $past(wdata_b)) && !bad_b);
   a_r9_reader_b: assert property (@(posedge clk_b) disable iff (!live_b)
      (en_b && !we_b && !rst_b && en_a && we_a && meet) |=> bad_b);
   a_r9_reader_a: assert property (@(posedge clk_a) disable iff (!live_a)
      (en_a && !we_a && !rst_a && en_b && we_b && meet) |=> bad_a);
   a_r10_sticky: assert property (@(posedge clk_a) disable iff (!live_a)
      (coll && !rst_a) |=> coll);
   a_r10_clear: assert property (@(posedge clk_a) disable iff (!live_a)
      rst_a |=> !coll);
endmodule

bind mwtdp_ram mwtdp_ram_chk #(.WA(WA), .WB(WB), .AWA(AWA), .AWB(AWB)) u_chk (
   .clk_a(a_clk_e), .clk_b(b_clk_e),
   .en_a(a_en_e), .we_a(a_we_e), .rst_a(a_rst_e), .addr_a(a_addr),
   .wdata_a(a_wdata), .rdata_a(a_rdata), .bad_a(a_bad),
   .en_b(b_en_e), .we_b(b_we_e), .rst_b(b_rst_e), .addr_b(b_addr),
   .wdata_b(b_wdata), .rdata_b(b_rdata), .bad_b(b_bad),
   .coll(coll_flag));

// File: tb/mwtdp_ram_tb.sv
module mwtdp_ram_tb_top;
   localparam int NB = 4096;
   localparam logic [15:0][255:0] TB_INIT = {
      256'h0, 256'h0, 256'h0, 256'h0, 256'h0, 256'h0, 256'h0, 256'h0,
      256'h0, 256'h0, 256'h0, 256'h0,
      {8{32'hDEAD_0001}},
      256'h0, 256'h0,
      256'h0123456789ABCDEF_FEDCBA9876543210_0F1E2D3C4B5A6978_8796A5B4C3D2E1F0};

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic a_en, a_we, a_srst, b_en, b_we, b_srst;
   logic [7:0]  a_addr;
   logic [15:0] a_wdata, a_rdata;
   logic [9:0]  b_addr;
   logic [3:0]  b_wdata, b_rdata;
   logic a_bad, b_bad, coll_flag, b_clk;
   assign b_clk = ~clk;

   mwtdp_ram #(.WA(16), .WB(4), .INV_CLK_B(1'b1), .INV_EN_B(1'b1),
               .INV_WE_B(1'b1), .INV_RST_B(1'b1), .INIT_VEC(TB_INIT)) dut_i (
      .a_clk(clk), .a_en(a_en), .a_we(a_we), .a_srst(a_srst), .a_addr(a_addr),
      .a_wdata(a_wdata), .a_rdata(a_rdata), .a_bad(a_bad),
      .b_clk(b_clk), .b_en(b_en), .b_we(b_we), .b_srst(b_srst), .b_addr(b_addr),
      .b_wdata(b_wdata), .b_rdata(b_rdata), .b_bad(b_bad), .coll_flag(coll_flag));

   // behavioural reference state
   bit        mem [NB];
   bit        psn [NB];
   bit [15:0] ea;
   bit [3:0]  eb;
   bit        eab, ebb, ec;
   int        errors = 0, checks = 0;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one clock: logical controls in, B pins driven inverted
   task automatic step(string tag,
                       input bit aen, input bit awe, input bit arst,
                       input int aad, input int ad,
                       input bit ben, input bit bwe, input bit brst,
                       input int bad_, input int bd);
      int sa, sb;
      bit meet, rd_psn;
      bit [15:0] w;
      a_en = aen; a_we = awe; a_srst = arst; a_addr = 8'(aad); a_wdata = 16'(ad);
      b_en = ~ben; b_we = ~bwe; b_srst = ~brst; b_addr = 10'(bad_); b_wdata = 4'(bd);
      sa = aad * 16; sb = bad_ * 4;
      meet = (sa < sb + 4) && (sb < sa + 16);
      // port A output
      if (arst) begin ea = 0; eab = 0; end
      else if (aen) begin
         if (awe) begin ea = 16'(ad); eab = 0; end
         else begin
            rd_psn = 0;
            for (int j = 0; j < 16; j++) begin w[j] = mem[sa+j]; rd_psn |= psn[sa+j]; end
            ea = w; eab = rd_psn || (ben && bwe && meet);
         end
      end
      // port B output
      if (brst) begin eb = 0; ebb = 0; end
      else if (ben) begin
         if (bwe) begin eb = 4'(bd); ebb = 0; end
         else begin
            rd_psn = 0;
            for (int j = 0; j < 4; j++) begin eb[j] = mem[sb+j]; rd_psn |= psn[sb+j]; end
            ebb = rd_psn || (aen && awe && meet);
         end
      end
      if (arst) ec = 0;
      else if (aen && ben && (awe || bwe) && meet) ec = 1;
      // storage
      if (ben && bwe)
         for (int j = 0; j < 4; j++) begin
            mem[sb+j] = bd[j];
            psn[sb+j] = aen && awe && (sb+j >= sa) && (sb+j < sa+16);
         end
      if (aen && awe)
         for (int j = 0; j < 16; j++) begin
            mem[sa+j] = ad[j];
            psn[sa+j] = ben && bwe && (sa+j >= sb) && (sa+j < sb+4);
         end
      @(posedge clk);
      @(negedge clk);
      chk(tag, "a_bad", int'(a_bad), int'(eab));
      if (!eab) chk(tag, "a_rdata", int'(a_rdata), int'(ea));
      chk(tag, "b_bad", int'(b_bad), int'(ebb));
      if (!ebb) chk(tag, "b_rdata", int'(b_rdata), int'(eb));
      chk(tag, "coll_flag", int'(coll_flag), int'(ec));
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

   initial begin
      for (int i = 0; i < NB; i++) begin mem[i] = TB_INIT[i/256][i%256]; psn[i] = 0; end
      ea = 0; eb = 0; eab = 0; ebb = 0; ec = 0;
      // R5 reset state: both outputs cleared
      step("R5", 0,0,1, 0,0,  0,0,1, 0,0);
      // R7 init image, R2 plain reads, R6 on inverted port B
      step("R7", 1,0,0, 0,0,  1,0,0, 1,0);
      step("R7", 1,0,0, 2,0,  1,0,0, 200,0);
      step("R7", 1,0,0, 48,0, 1,0,0, 193,0);
      step("R2", 1,0,0, 20,0, 0,0,0, 0,0);
      // R3 mirror and R1 cross-width readback
      step("R3", 1,1,0, 5,16'hBEEF, 1,1,0, 40,7);
      step("R1", 1,0,0, 10,0, 1,0,0, 20,0);
      step("R1", 0,0,0, 0,0,  1,0,0, 23,0);
      step("R6", 0,0,0, 0,0,  1,0,0, 21,0);
      // R4 disabled write is ignored, output holds
      step("R4", 0,1,0, 5,16'h1111, 0,1,0, 40,9);
      step("R4", 1,0,0, 5,0,  1,0,0, 40,0);
      // R5 clear with a write in flight; other port unaffected
      step("R5", 1,1,1, 7,16'h5A5A, 1,0,0, 41,0);
      step("R5", 1,0,0, 7,0,  1,1,1, 90,3);
      step("R5", 0,0,0, 0,0,  1,0,0, 90,0);
      // R9 write while other reads, R10 sticky flag
      step("R9", 1,1,0, 12,16'hC0DE, 1,0,0, 49,0);
      step("R9", 1,0,0, 12,0, 1,1,0, 50,6);
      step("R10", 0,0,0, 0,0, 0,0,0, 0,0);
      step("R10", 1,0,1, 0,0, 0,0,0, 0,0);
      // R8 write-write poison, partial overlap, then clean rewrite
      step("R8", 1,1,0, 30,16'h1234, 1,1,0, 121,15);
      step("R8", 1,0,0, 30,0, 1,0,0, 120,0);
      step("R8", 0,0,0, 0,0, 1,0,0, 121,0);
      step("R8", 1,1,0, 30,16'h9876, 0,0,0, 0,0);
      step("R8", 1,0,0, 30,0, 1,0,0, 121,0);
      step("R10", 1,1,0, 31,16'h4242, 1,1,0, 0,5);
      // mixed traffic on a small window for frequent overlaps
      for (int n = 0; n < 600; n++) begin
         int r;
         r = int'($urandom);
         step("R2", r[0], r[1], (r[7:2] == 0), r[10:8], int'($urandom) & 16'hFFFF,
              r[11], r[12], (r[18:13] == 0), r[23:19], r[27:24]);
      end
      report();
      $finish;
   end
endmodule